// File: doc/BRIEF.md
# Token-Ring Controller Command Decoder

This block sits between a host bus and the token-passing engine of a network controller. The host writes single command bytes. The block decodes each byte and records a pending transmit or receive request together with the buffer page that request uses. It also keeps the status flags the host polls: transmitter available, transmit acknowledged, receiver inhibited, power-on reset, reconfiguration and excessive NAK.

The engine reports what happens on the wire through single-cycle strobes: a token arrived, a reception is in progress, a reception finished, a transmission finished, and an ACK came back. The block answers with an 11-bit start address for each direction, a broadcast-accept bit, a long-packet enable, a launch pulse when a armed transmission takes the token, and one-cycle pulses for the commands that belong to other logic (restart, DMA-end mask clear, interrupt clears used in chained mode).

A disable command does not act when it is written. It waits for the next token arrival. A reception that is already running is always allowed to finish.

Top module: `tr_cmd_decoder`

## Requirements
- R1: After reset, tx_avail=1, rx_inhib=1, por_flag=1, and tx_acked, recon_flag, nak_flag, tx_pending, rx_enabled, long_en and bcast_en are all 0.
- R2: The enable-transmit byte `00fnn011` sets tx_avail=0, tx_acked=0 and tx_pending=1 on the next cycle, and sets tx_start to {nn, f, 8'h00}. This byte is ignored while a transmission is in progress.
- R3: A token arrival with a transmit armed and no deferred disable gives a one-cycle tx_go pulse and clears tx_pending. During that transmission, ack_rcvd sets tx_acked. tx_done sets tx_avail=1.
- R4: The enable-receive byte `b0fnn100` (bit 6 = 0) sets rx_inhib=0 and rx_enabled=1, sets rx_start to {nn, f, 8'h00}, and sets bcast_en to b (bit 7).
- R5: rx_done sets rx_inhib=1 and clears rx_enabled.
- R6: The byte 0x01 (disable transmitter) changes no output when written. At the next token arrival it drops the armed request, sets tx_avail=1 and gives no tx_go.
- R7: The byte 0x02 (disable receiver) changes no output when written. At the next token arrival with rx_busy=0, it sets rx_inhib=1 and clears rx_enabled. If rx_busy=1 at that token, the receiver stays enabled until rx_done.
- R8: The configuration byte `0000c101` sets long_en to c (bit 3).
- R9: The byte `000rp110` clears por_flag and nak_flag when p (bit 3) is 1, and clears recon_flag when r (bit 4) is 1. The strobes recon_evt and nak_evt set recon_flag and nak_flag.
- R10: Each of the bytes 0x18, 0x10, 0x00 and 0x08 gives a one-cycle pulse, on restart_pulse, dma_mask_clr, tx_int_clr and rx_int_clr respectively, in the cycle after the write.
- R11: A byte that matches none of the patterns above changes no output and gives no pulse.
- R12: When a command write and an engine strobe fall in the same cycle, the strobe is applied first and the command second. Example: tx_done together with enable-transmit leaves tx_avail=0 and tx_pending=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte |
| tok_arrive | input | 1 | Token arrived at this node |
| rx_busy | input | 1 | A packet is being received |
| rx_done | input | 1 | A packet was received successfully |
| tx_done | input | 1 | The transmit sequence finished |
| ack_rcvd | input | 1 | The destination acknowledged |
| recon_evt | input | 1 | A network reconfiguration was seen |
| nak_evt | input | 1 | An excessive-NAK condition was seen |
| tx_avail | output | 1 | Transmitter available flag |
| tx_acked | output | 1 | Transmit acknowledged flag |
| rx_inhib | output | 1 | Receiver inhibited flag |
| por_flag | output | 1 | Power-on reset flag |
| recon_flag | output | 1 | Reconfiguration flag |
| nak_flag | output | 1 | Excessive-NAK flag |
| tx_pending | output | 1 | A transmit is armed and waiting for the token |
| rx_enabled | output | 1 | A receive request is active |
| tx_start | output | 11 | Transmit buffer start address |
| rx_start | output | 11 | Receive buffer start address |
| bcast_en | output | 1 | Accept packets sent to ID zero |
| long_en | output | 1 | Long packets allowed |
| tx_go | output | 1 | One-cycle pulse: start transmitting |
| restart_pulse | output | 1 | One-cycle pulse: resume internal operation |
| dma_mask_clr | output | 1 | One-cycle pulse: clear the DMA-end mask |
| tx_int_clr | output | 1 | One-cycle pulse: chained transmit-interrupt clear |
| rx_int_clr | output | 1 | One-cycle pulse: chained receive-interrupt clear |

## Verification
Each bad internal bit becomes visible at a port within one cycle of the event that reads it. A deferred disable that was lost or applied early changes tx_avail, rx_inhib or rx_enabled at the first token instead of leaving them alone, or the other way round. A wrong transmit-active bit shows as a tx_go that is missing or doubled, or as a re-arm that should have been ignored. A decoder that lets an unlisted byte through is visible on the cycle after the write, in the flags, the page addresses or the pulse outputs. The bench therefore checks every output on the cycle right after each write or strobe.

// File: rtl/tr_cmd_decoder.sv
module tr_cmd_decoder #(
  parameter int PAGE_W = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [7:0]  cmd_data,
  input  logic        tok_arrive,
  input  logic        rx_busy,
  input  logic        rx_done,
  input  logic        tx_done,
  input  logic        ack_rcvd,
  input  logic        recon_evt,
  input  logic        nak_evt,
  output logic        tx_avail,
  output logic        tx_acked,
  output logic        rx_inhib,
  output logic        por_flag,
  output logic        recon_flag,
  output logic        nak_flag,
  output logic        tx_pending,
  output logic        rx_enabled,
  output logic [10:0] tx_start,
  output logic [10:0] rx_start,
  output logic        bcast_en,
  output logic        long_en,
  output logic        tx_go,
  output logic        restart_pulse,
  output logic        dma_mask_clr,
  output logic        tx_int_clr,
  output logic        rx_int_clr
);
  localparam int SEL_W = PAGE_W + 1;

  logic [SEL_W-1:0] tx_sel, rx_sel;
  logic tx_active, tx_kill, rx_kill;

  assign tx_start = {tx_sel, 8'h00};
  assign rx_start = {rx_sel, 8'h00};

  wire c_rxen  = cmd_data[2:0] == 3'b100 && !cmd_data[6];
  wire c_txen  = cmd_data[2:0] == 3'b011 && cmd_data[7:6] == 2'b00;
  wire c_cfg   = cmd_data[2:0] == 3'b101 && cmd_data[7:4] == 4'h0;
  wire c_clr   = cmd_data[2:0] == 3'b110 && cmd_data[7:5] == 3'b000;
  wire c_txdis = cmd_data == 8'h01;
  wire c_rxdis = cmd_data == 8'h02;

  wire launch  = tok_arrive && tx_pending && !tx_kill;
  wire act_nx  = (tx_active && !tx_done) || launch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_avail <= 1'b1; tx_acked <= 1'b0; rx_inhib <= 1'b1;
      por_flag <= 1'b1; recon_flag <= 1'b0; nak_flag <= 1'b0;
      tx_pending <= 1'b0; rx_enabled <= 1'b0; tx_active <= 1'b0;
      tx_kill <= 1'b0; rx_kill <= 1'b0;
      tx_sel <= '0; rx_sel <= '0; bcast_en <= 1'b0; long_en <= 1'b0;
      tx_go <= 1'b0; restart_pulse <= 1'b0; dma_mask_clr <= 1'b0;
      tx_int_clr <= 1'b0; rx_int_clr <= 1'b0;
    end else begin
      tx_go <= 1'b0;
      restart_pulse <= cmd_wr && cmd_data == 8'h18;
      dma_mask_clr  <= cmd_wr && cmd_data == 8'h10;
      tx_int_clr    <= cmd_wr && cmd_data == 8'h00;
      rx_int_clr    <= cmd_wr && cmd_data == 8'h08;

      if (tok_arrive) begin
        if (tx_kill) begin
          tx_pending <= 1'b0; tx_avail <= 1'b1; tx_kill <= 1'b0;
        end else if (tx_pending) begin
          tx_pending <= 1'b0; tx_active <= 1'b1; tx_go <= 1'b1;
        end
        if (rx_kill && !rx_busy) begin
          rx_enabled <= 1'b0; rx_inhib <= 1'b1; rx_kill <= 1'b0;
        end
      end
      if (tx_done && tx_active) begin
        tx_active <= 1'b0; tx_avail <= 1'b1;
      end
      if (ack_rcvd && tx_active) tx_acked <= 1'b1;
      if (rx_done) begin
        rx_inhib <= 1'b1; rx_enabled <= 1'b0; rx_kill <= 1'b0;
      end
      if (recon_evt) recon_flag <= 1'b1;
      if (nak_evt) nak_flag <= 1'b1;

      if (cmd_wr) begin
        if (c_txen && !act_nx) begin
          tx_pending <= 1'b1; tx_avail <= 1'b0; tx_acked <= 1'b0;
          tx_kill <= 1'b0; tx_sel <= {cmd_data[4:3], cmd_data[5]};
        end
        if (c_rxen) begin
          rx_enabled <= 1'b1; rx_inhib <= 1'b0; rx_kill <= 1'b0;
          bcast_en <= cmd_data[7]; rx_sel <= {cmd_data[4:3], cmd_data[5]};
        end
        if (c_txdis && !act_nx) tx_kill <= 1'b1;
        if (c_rxdis) rx_kill <= 1'b1;
        if (c_cfg) long_en <= cmd_data[3];
        if (c_clr) begin
          if (cmd_data[3]) begin por_flag <= 1'b0; nak_flag <= 1'b0; end
          if (cmd_data[4]) recon_flag <= 1'b0;
        end
      end
    end
  end

  assert_go_on_token_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> $past(tok_arrive) && !tx_pending);
  assert_avail_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_avail) |-> $past(cmd_wr) && tx_pending);
  assert_inhib_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_inhib) |-> $past(tok_arrive || rx_done) && !rx_enabled);
  assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({restart_pulse, dma_mask_clr, tx_int_clr, rx_int_clr}));
  assert_por_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_flag) |-> $past(cmd_wr && cmd_data[3]));
  assert_junk_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !(c_rxen || c_txen || c_cfg || c_clr || c_txdis || c_rxdis)
     && !(tok_arrive || rx_done || tx_done || ack_rcvd || recon_evt || nak_evt))
    |=> $stable({tx_avail, tx_acked, rx_inhib, por_flag, recon_flag, nak_flag,
                 tx_pending, rx_enabled, tx_start, rx_start, bcast_en, long_en}));
endmodule

// File: tb/sim_tr_cmd_decoder.sv
module sim_tr_cmd_decoder;
  logic clk = 1'b0, rst_n = 1'b0, cmd_wr = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic tok_arrive = 0, rx_busy = 0, rx_done = 0, tx_done = 0, ack_rcvd = 0;
  logic recon_evt = 0, nak_evt = 0;
  logic tx_avail, tx_acked, rx_inhib, por_flag, recon_flag, nak_flag;
  logic tx_pending, rx_enabled, bcast_en, long_en, tx_go;
  logic restart_pulse, dma_mask_clr, tx_int_clr, rx_int_clr;
  logic [10:0] tx_start, rx_start;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  tr_cmd_decoder u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); cmd_wr = 1; cmd_data = b;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic tick(input int which, input bit busy);
    @(negedge clk);
    rx_busy = busy;
    case (which)
      0: tok_arrive = 1; 1: rx_done = 1; 2: tx_done = 1;
      3: ack_rcvd = 1; 4: recon_evt = 1; default: nak_evt = 1;
    endcase
    @(negedge clk);
    {tok_arrive, rx_done, tx_done, ack_rcvd, recon_evt, nak_evt} = '0;
  endtask

  task automatic t_reset;
    chk("R1 tx_avail", tx_avail, 1); chk("R1 rx_inhib", rx_inhib, 1);
    chk("R1 por", por_flag, 1); chk("R1 acked", tx_acked, 0);
    chk("R1 recon", recon_flag, 0); chk("R1 nak", nak_flag, 0);
    chk("R1 pending", tx_pending, 0); chk("R1 rx_en", rx_enabled, 0);
    chk("R1 long", long_en, 0); chk("R1 bcast", bcast_en, 0);
  endtask

  task automatic t_transmit;
    wr(8'h3B);
    chk("R2 avail", tx_avail, 0); chk("R2 pending", tx_pending, 1);
    chk("R2 start", tx_start, 11'h700); chk("R2 acked", tx_acked, 0);
    tick(0, 0);
    chk("R3 go", tx_go, 1); chk("R3 pending", tx_pending, 0);
    @(negedge clk); chk("R3 go width", tx_go, 0);
    wr(8'h13);
    chk("R2 ignored while active", tx_pending, 0);
    chk("R2 start kept", tx_start, 11'h700);
    tick(3, 0); chk("R3 acked", tx_acked, 1); chk("R3 avail busy", tx_avail, 0);
    tick(2, 0); chk("R3 avail", tx_avail, 1);
    wr(8'h03); chk("R2 acked cleared", tx_acked, 0); chk("R2 start 0", tx_start, 0);
    tick(0, 0); tick(2, 0);
  endtask

  task automatic t_receive;
    wr(8'h8C);
    chk("R4 inhib", rx_inhib, 0); chk("R4 en", rx_enabled, 1);
    chk("R4 start", rx_start, 11'h200); chk("R4 bcast", bcast_en, 1);
    wr(8'h24);
    chk("R4 start f", rx_start, 11'h100); chk("R4 bcast off", bcast_en, 0);
    tick(1, 0);
    chk("R5 inhib", rx_inhib, 1); chk("R5 en", rx_enabled, 0);
  endtask

  task automatic t_tx_disable;
    wr(8'h03); wr(8'h01);
    chk("R6 deferred avail", tx_avail, 0); chk("R6 deferred pend", tx_pending, 1);
    tick(0, 0);
    chk("R6 avail", tx_avail, 1); chk("R6 pend", tx_pending, 0); chk("R6 no go", tx_go, 0);
  endtask

  task automatic t_rx_disable;
    wr(8'h04); wr(8'h02);
    chk("R7 deferred", rx_inhib, 0);
    tick(0, 1);
    chk("R7 busy inhib", rx_inhib, 0); chk("R7 busy en", rx_enabled, 1);
    tick(1, 0); chk("R7 done inhib", rx_inhib, 1);
    wr(8'h04); wr(8'h02); tick(0, 0);
    chk("R7 idle inhib", rx_inhib, 1); chk("R7 idle en", rx_enabled, 0);
  endtask

  task automatic t_config;
    wr(8'h0D); chk("R8 long on", long_en, 1);
    wr(8'h05); chk("R8 long off", long_en, 0);
  endtask

  task automatic t_flags;
    tick(4, 0); tick(5, 0);
    chk("R9 recon set", recon_flag, 1); chk("R9 nak set", nak_flag, 1);
    wr(8'h0E);
    chk("R9 por", por_flag, 0); chk("R9 nak", nak_flag, 0); chk("R9 recon kept", recon_flag, 1);
    wr(8'h16); chk("R9 recon", recon_flag, 0);
  endtask

  task automatic t_pulses;
    wr(8'h18); chk("R10 restart", {restart_pulse, dma_mask_clr, tx_int_clr, rx_int_clr}, 4'b1000);
    @(negedge clk); chk("R10 restart width", restart_pulse, 0);
    wr(8'h10); chk("R10 dma", {restart_pulse, dma_mask_clr, tx_int_clr, rx_int_clr}, 4'b0100);
    wr(8'h00); chk("R10 txint", {restart_pulse, dma_mask_clr, tx_int_clr, rx_int_clr}, 4'b0010);
    wr(8'h08); chk("R10 rxint", {restart_pulse, dma_mask_clr, tx_int_clr, rx_int_clr}, 4'b0001);
  endtask

  task automatic t_junk;
    logic [39:0] snap;
    wr(8'h0D); wr(8'h8C);
    snap = {tx_avail, tx_acked, rx_inhib, por_flag, recon_flag, nak_flag,
            tx_pending, rx_enabled, tx_start, rx_start, bcast_en, long_en, 4'h0};
    foreach (snap[i]) if (i < 0) snap[i] = 0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = (k == 0) ? 8'h07 : (k == 1) ? 8'hFF : (k == 2) ? 8'h20 : 8'h43;
      wr(b);
      chk("R11 state", {tx_avail, tx_acked, rx_inhib, por_flag, recon_flag, nak_flag,
          tx_pending, rx_enabled, tx_start, rx_start, bcast_en, long_en} == snap[39:4], 1);
      chk("R11 pulses", {restart_pulse, dma_mask_clr, tx_int_clr, rx_int_clr, tx_go}, 0);
    end
  endtask

  task automatic t_order;
    wr(8'h03); tick(0, 0);
    @(negedge clk); tx_done = 1; cmd_wr = 1; cmd_data = 8'h0B;
    @(negedge clk); tx_done = 0; cmd_wr = 0;
    chk("R12 avail", tx_avail, 0); chk("R12 pend", tx_pending, 1);
    chk("R12 start", tx_start, 11'h200);
    @(negedge clk); rx_done = 1; cmd_wr = 1; cmd_data = 8'h04;
    @(negedge clk); rx_done = 0; cmd_wr = 0;
    chk("R12 inhib", rx_inhib, 0); chk("R12 rx en", rx_enabled, 1);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_transmit; t_receive; t_tx_disable; t_rx_disable;
    t_config; t_flags; t_pulses; t_junk; t_order;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule